// File: doc/BRIEF.md
# BCD Real-Time Clock with Countdown Timer, Stopwatch and Alarm

This peripheral keeps a 24-hour time of day, a minutes:seconds countdown timer, a stopwatch with hundredth-of-a-second resolution and an alarm comparator. All four share one periodic tick enable. Every value is held as packed binary-coded decimal, and each counter steps through decimal carries, so software reads values that can be printed digit by digit with no conversion.

Software drives a simple register port. A write strobe carries a two-bit register select and a 32-bit data word. Writes are checked digit by digit, and a value that is not legal BCD for its field is dropped whole. The read port is combinational on its select. The stopwatch advances once per tick, which is meant to be a 100 Hz enable. The clock and the timer advance once every `TICKS_PER_SEC` ticks. The timer and the alarm each drive a sticky interrupt level.

Register select: 0 = clock, 1 = timer, 2 = stopwatch, 3 = alarm.

Top module: `bcd_rtc_top`

## Requirements
- R1: After reset every register reads zero, the timer and stopwatch are stopped, the alarm is disabled, and both `timerIrq` and `alarmIrq` are low.
- R2: A valid write to select 0 loads hours, minutes and seconds from data bits 23:16, 15:8 and 7:0 as BCD. It also restarts the second prescaler, so the clock advances by one second after exactly `TICKS_PER_SEC` further tick pulses, and not before. A read of select 0 returns the time in bits 23:0, with zeros above.
- R3: The clock carries in decimal. A units digit goes from 9 to 0 and carries into its tens digit. Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00.
- R4: A write is ignored when any BCD digit in its time field exceeds 9, or minutes or seconds exceed 59, or hours exceed 23. This applies to the clock, timer and alarm selects. A stopwatch write whose data is not exactly 0, 1 or 2 is also ignored.
- R5: A valid write to select 1 loads minutes from bits 15:8 and seconds from bits 7:0. If the value is nonzero, the countdown starts and the value drops by one second on each clock second, borrowing across minutes. A timer read returns the value in bits 15:0, the running flag in bit 24 and the expired flag in bit 25.
- R6: When the timer reaches 00:00 it stops and sets a sticky expired flag, which drives `timerIrq`. The flag stays set until the next valid timer write clears it.
- R7: Stopwatch write commands: 1 starts counting, 0 stops it, and 2 zeroes the count without changing the run state. A stopwatch read returns the running flag in bit 24.
- R8: While running, the stopwatch adds one hundredth per tick. It holds BCD minutes, seconds and hundredths in bits 23:16, 15:8 and 7:0. Hundredths wrap 99 to 00 into seconds, seconds wrap 59 into minutes, and minutes wrap 59 to 00.
- R9: A valid write to select 3 loads the alarm time from bits 23:0 and the enable from bit 24, and clears the alarm flag. The flag, read at bit 25, drives `alarmIrq`. When the enable is set and the clock equals the alarm time, the flag is set one cycle later and the enable clears, so the alarm fires once. With the enable clear, a match does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Periodic enable, one hundredth of a second per pulse |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write register select |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read register select |
| rdData | output | 32 | Read data for the selected register |
| timerIrq | output | 1 | Timer expired flag |
| alarmIrq | output | 1 | Alarm fired flag |

## Verification
On every cycle, the assertions check several invariants. The clock and stopwatch digits always stay legal BCD within their ranges. The clock and the stopwatch hold still when nothing steps or loads them. The prescaler stays in range. The timer expires only at zero and with its run flag down. The alarm flag rises only out of an armed state that it then disarms. The bench's scenarios are the only place to show the actual arithmetic. They cover the exact decimal carries and wraps, the one-second spacing after a clock load, and the borrow across a timer minute. They also cover the stopwatch commands, the dropping of illegal writes, and that the alarm does not fire a second time.

// File: rtl/rtcPkg.sv
package rtcPkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CLOCK = 2'd0,
    REG_TIMER = 2'd1,
    REG_STOPW = 2'd2,
    REG_ALARM = 2'd3
  } regSelT;

  // three BCD digit pairs, index 0 is the least significant pair
  typedef logic [2:0][7:0] tripleT;
  typedef logic [1:0][7:0] pairsT;

  localparam tripleT HMS_MAX = {8'h23, 8'h59, 8'h59};
  localparam tripleT SW_MAX  = {8'h59, 8'h59, 8'h99};

  typedef struct packed {
    logic centiStep;
    logic secStep;
    logic ldClock;
    logic ldTimer;
    logic ldAlarm;
    logic swStart;
    logic swStop;
    logic swClear;
  } ctrlStrobeT;

  function automatic logic pairOk(input logic [7:0] v, input logic [7:0] maxV);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v <= maxV);
  endfunction

  // returns {wrap, next}
  function automatic logic [8:0] pairUp(input logic [7:0] v, input logic [7:0] maxV);
    logic [3:0] hi;
    hi = v[7:4] + 4'd1;
    if (v >= maxV)          return {1'b1, 8'h00};
    else if (v[3:0] >= 4'd9) return {1'b0, hi, 4'd0};
    else                    return {1'b0, v[7:4], v[3:0] + 4'd1};
  endfunction

  // returns {borrow, next}
  function automatic logic [8:0] pairDown(input logic [7:0] v, input logic [7:0] maxV);
    logic [3:0] hi;
    hi = v[7:4] - 4'd1;
    if (v == 8'h00)          return {1'b1, maxV};
    else if (v[3:0] == 4'd0) return {1'b0, hi, 4'd9};
    else                     return {1'b0, v[7:4], v[3:0] - 4'd1};
  endfunction

  function automatic tripleT tripleUp(input tripleT v, input tripleT maxV);
    tripleT     n;
    logic       carry;
    logic [8:0] r;
    n     = v;
    carry = 1'b1;
    for (int i = 0; i < 3; i++) begin
      if (carry) begin
        r     = pairUp(v[i], maxV[i]);
        n[i]  = r[7:0];
        carry = r[8];
      end
    end
    return n;
  endfunction

  function automatic logic tripleOk(input tripleT v, input tripleT maxV);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 3; i++) ok = ok && pairOk(v[i], maxV[i]);
    return ok;
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtcPkg::*;
#(
  parameter int TICKS_PER_SEC = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  output ctrlStrobeT        strobes
);

  localparam int PRESC_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(TICKS_PER_SEC - 1);

  logic [PRESC_W-1:0] presc;
  logic               lastPhase;
  logic               hmsValid;
  logic               msValid;
  logic               selClock, selTimer, selStopw, selAlarm;

  assign lastPhase = (presc == PRESC_LAST);

  // digit-level legality of the incoming word
  assign hmsValid = tripleOk(tripleT'(wrData[23:0]), HMS_MAX);
  assign msValid  = pairOk(wrData[15:8], 8'h59) && pairOk(wrData[7:0], 8'h59);

  assign selClock = wrEn && (wrAddr == REG_CLOCK);
  assign selTimer = wrEn && (wrAddr == REG_TIMER);
  assign selStopw = wrEn && (wrAddr == REG_STOPW);
  assign selAlarm = wrEn && (wrAddr == REG_ALARM);

  always_comb begin
    strobes           = '0;
    strobes.centiStep = tick;
    strobes.secStep   = tick && lastPhase;
    strobes.ldClock   = selClock && hmsValid;
    strobes.ldTimer   = selTimer && msValid;
    strobes.ldAlarm   = selAlarm && hmsValid;
    strobes.swStop    = selStopw && (wrData == REG_W'(0));
    strobes.swStart   = selStopw && (wrData == REG_W'(1));
    strobes.swClear   = selStopw && (wrData == REG_W'(2));
  end

  // a clock load restarts the second phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                presc <= '0;
    else if (strobes.ldClock) presc <= '0;
    else if (tick)            presc <= lastPhase ? '0 : presc + PRESC_W'(1);
  end

  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(presc) < TICKS_PER_SEC); // R2

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.ldClock, strobes.ldTimer, strobes.ldAlarm,
              strobes.swStart, strobes.swStop, strobes.swClear})); // R4

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic [24:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output logic              timerIrq,
  output logic              alarmIrq
);

  tripleT clockQ, clockNext;
  tripleT alarmQ;
  logic   alarmEn, alarmFlag;
  pairsT  tmrQ, tmrNext;
  logic   tmrRun, tmrExp;
  tripleT swQ, swNext;
  logic   swRun;

  assign clockNext = tripleUp(clockQ, HMS_MAX);
  assign swNext    = tripleUp(swQ, SW_MAX);

  always_comb begin
    logic [8:0] sDn;
    logic [8:0] mDn;
    sDn        = pairDown(tmrQ[0], 8'h59);
    mDn        = pairDown(tmrQ[1], 8'h59);
    tmrNext[0] = sDn[7:0];
    tmrNext[1] = sDn[8] ? mDn[7:0] : tmrQ[1];
  end

  // time of day
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                clockQ <= '0;
    else if (strobes.ldClock) clockQ <= wrData[23:0];
    else if (strobes.secStep) clockQ <= clockNext;
  end

  // countdown timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrQ   <= '0;
      tmrRun <= 1'b0;
      tmrExp <= 1'b0;
    end else if (strobes.ldTimer) begin
      tmrQ   <= wrData[15:0];
      tmrRun <= (wrData[15:0] != 16'h0);
      tmrExp <= 1'b0;
    end else if (strobes.secStep && tmrRun) begin
      tmrQ <= tmrNext;
      if (tmrNext == '0) begin
        tmrRun <= 1'b0;
        tmrExp <= 1'b1;
      end
    end
  end

  // stopwatch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swQ   <= '0;
      swRun <= 1'b0;
    end else begin
      if (strobes.swStart)     swRun <= 1'b1;
      else if (strobes.swStop) swRun <= 1'b0;
      if (strobes.swClear)                     swQ <= '0;
      else if (strobes.centiStep && swRun)     swQ <= swNext;
    end
  end

  // alarm comparator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmQ    <= '0;
      alarmEn   <= 1'b0;
      alarmFlag <= 1'b0;
    end else if (strobes.ldAlarm) begin
      alarmQ    <= wrData[23:0];
      alarmEn   <= wrData[24];
      alarmFlag <= 1'b0;
    end else if (alarmEn && (clockQ == alarmQ)) begin
      alarmFlag <= 1'b1;
      alarmEn   <= 1'b0;
    end
  end

  always_comb begin
    case (rdAddr)
      REG_CLOCK: rdData = {8'h00, clockQ};
      REG_TIMER: rdData = {6'b0, tmrExp, tmrRun, 8'h00, tmrQ};
      REG_STOPW: rdData = {7'b0, swRun, swQ};
      default:   rdData = {6'b0, alarmFlag, alarmEn, alarmQ};
    endcase
  end

  assign timerIrq = tmrExp;
  assign alarmIrq = alarmFlag;

  AST_CLOCK_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    tripleOk(clockQ, HMS_MAX)); // R3

  AST_CLOCK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.secStep && !strobes.ldClock) |=> $stable(clockQ)); // R2

  AST_TIMER_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tmrExp) |-> (!tmrRun && tmrQ == '0)); // R6

  AST_TIMER_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (tmrExp && !strobes.ldTimer) |=> tmrExp); // R6

  AST_SW_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!swRun && !strobes.swClear) |=> $stable(swQ)); // R7

  AST_SW_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    tripleOk(swQ, SW_MAX)); // R8

  AST_ALARM_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> (!alarmEn && $past(alarmEn))); // R9

endmodule

// File: rtl/bcd_rtc_top.sv
module bcd_rtc_top
  import rtcPkg::*;
#(
  parameter int TICKS_PER_SEC = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [1:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        timerIrq,
  output logic        alarmIrq
);

  ctrlStrobeT strobes;

  rtc_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strobes (strobes)
  );

  rtc_datapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData[24:0]),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .timerIrq (timerIrq),
    .alarmIrq (alarmIrq)
  );

endmodule

// File: tb/sim_bcd_rtc_top.sv
`timescale 1ns/1ps
module sim_bcd_rtc_top;

  localparam int TPS = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [31:0] wrData = 32'h0;
  logic [1:0]  rdAddr = 2'd0;
  logic [31:0] rdData;
  logic        timerIrq, alarmIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bcd_rtc_top #(.TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .timerIrq(timerIrq), .alarmIrq(alarmIrq)
  );

  task automatic expectVal(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkReg(input string req, input logic [1:0] a, input logic [31:0] exp);
    rdAddr = a;
    #1;
    expectVal(req, $sformatf("reg%0d", a), rdData, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic testReset();
    for (int a = 0; a < 4; a++) checkReg("R1", 2'(a), 32'h0);
    expectVal("R1", "timerIrq", {31'b0, timerIrq}, 32'h0);
    expectVal("R1", "alarmIrq", {31'b0, alarmIrq}, 32'h0);
  endtask

  task automatic testIgnoredIdle();
    wr(2'd1, 32'h0000_0060);  checkReg("R4 timer sec60", 2'd1, 32'h0);
    wr(2'd1, 32'h0000_0A00);  checkReg("R4 timer digit", 2'd1, 32'h0);
    wr(2'd3, 32'h0124_0000);  checkReg("R4 alarm hr24", 2'd3, 32'h0);
    wr(2'd2, 32'h0000_0003);  ticks(3);
    checkReg("R4 stopwatch cmd3", 2'd2, 32'h0);
    wr(2'd2, 32'h0001_0001);  ticks(2);
    checkReg("R4 stopwatch wide", 2'd2, 32'h0);
  endtask

  task automatic testClock();
    wr(2'd0, 32'h0021_0837);
    checkReg("R2 load", 2'd0, 32'h0021_0837);
    ticks(TPS - 1);
    checkReg("R2 not yet", 2'd0, 32'h0021_0837);
    ticks(1);
    checkReg("R2 one second", 2'd0, 32'h0021_0838);
    ticks(2 * TPS);
    checkReg("R2 three seconds", 2'd0, 32'h0021_0840);
  endtask

  task automatic testRollover();
    wr(2'd0, 32'h0023_5959); ticks(TPS);
    checkReg("R3 day wrap", 2'd0, 32'h0000_0000);
    wr(2'd0, 32'h0012_0959); ticks(TPS);
    checkReg("R3 min digit", 2'd0, 32'h0012_1000);
    wr(2'd0, 32'h0009_5959); ticks(TPS);
    checkReg("R3 hour digit", 2'd0, 32'h0010_0000);
    wr(2'd0, 32'h0000_0009); ticks(TPS);
    checkReg("R3 sec digit", 2'd0, 32'h0000_0010);
  endtask

  task automatic testClockIgnored();
    wr(2'd0, 32'h0015_3045);
    wr(2'd0, 32'h0024_0000); checkReg("R4 clock hr24", 2'd0, 32'h0015_3045);
    wr(2'd0, 32'h0012_6000); checkReg("R4 clock min60", 2'd0, 32'h0015_3045);
    wr(2'd0, 32'h0010_001F); checkReg("R4 clock digit", 2'd0, 32'h0015_3045);
  endtask

  task automatic testTimer();
    wr(2'd0, 32'h0000_0000);
    wr(2'd1, 32'h0000_0002);
    checkReg("R5 load", 2'd1, 32'h0100_0002);
    ticks(TPS);
    checkReg("R5 step", 2'd1, 32'h0100_0001);
    ticks(TPS);
    checkReg("R6 expired", 2'd1, 32'h0200_0000);
    expectVal("R6", "timerIrq set", {31'b0, timerIrq}, 32'h1);
    ticks(TPS);
    checkReg("R6 sticky", 2'd1, 32'h0200_0000);
    wr(2'd1, 32'h0000_0130);
    checkReg("R6 cleared", 2'd1, 32'h0100_0130);
    expectVal("R6", "timerIrq clear", {31'b0, timerIrq}, 32'h0);
    ticks(TPS);
    checkReg("R5 tens borrow", 2'd1, 32'h0100_0129);
    wr(2'd1, 32'h0000_0100);
    ticks(TPS);
    checkReg("R5 minute borrow", 2'd1, 32'h0100_0059);
    wr(2'd1, 32'h0000_0000);
  endtask

  task automatic testStopwatch();
    wr(2'd2, 32'h1);
    checkReg("R7 start", 2'd2, 32'h0100_0000);
    ticks(3);
    checkReg("R8 count", 2'd2, 32'h0100_0003);
    wr(2'd2, 32'h0);
    ticks(5);
    checkReg("R7 stopped", 2'd2, 32'h0000_0003);
    wr(2'd2, 32'h2);
    checkReg("R7 clear", 2'd2, 32'h0000_0000);
    wr(2'd2, 32'h1);
    ticks(10);
    checkReg("R8 digit carry", 2'd2, 32'h0100_0010);
    ticks(90);
    checkReg("R8 hundredths wrap", 2'd2, 32'h0100_0100);
    wr(2'd2, 32'h2);
    checkReg("R7 clear keeps run", 2'd2, 32'h0100_0000);
    wr(2'd2, 32'h0);
  endtask

  task automatic testAlarm();
    wr(2'd0, 32'h0010_5958);
    wr(2'd3, 32'h0110_5959);
    checkReg("R9 load", 2'd3, 32'h0110_5959);
    expectVal("R9", "alarmIrq before", {31'b0, alarmIrq}, 32'h0);
    ticks(TPS);
    @(negedge clk);
    checkReg("R9 fired", 2'd3, 32'h0210_5959);
    expectVal("R9", "alarmIrq set", {31'b0, alarmIrq}, 32'h1);
    wr(2'd3, 32'h0011_0001);
    checkReg("R9 flag cleared", 2'd3, 32'h0011_0001);
    ticks(2 * TPS);
    @(negedge clk);
    checkReg("R9 disabled match clock", 2'd0, 32'h0011_0001);
    expectVal("R9", "alarmIrq disabled", {31'b0, alarmIrq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIgnoredIdle();
    testClock();
    testRollover();
    testClockIgnored();
    testTimer();
    testStopwatch();
    testAlarm();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule